// File: doc/BRIEF.md
# Overlapping Multi-Width Floating-Point Register File

This block holds the floating-point register state of a core as one flat array of 32-bit words. The same words are reached at three access sizes: a single (32 bits), a double (64 bits) or a quad (128 bits). A register number `n` always selects word `n` as the first word of the access. A wider access also takes the words that follow it, so the registers of different sizes share and overlap the same storage. A double write therefore changes the two singles it covers. A later single read returns the half it asked for.

There is one combinational read port and one synchronous write port, and each carries its own width code. An access with an illegal code is flagged on an error output and has no effect. So is a quad write, which is unsupported, and so is any access whose words would run past the top of the array. A synchronous clear zeroes the whole array. Values wider than one word are laid out big-endian by word: the lower-numbered word carries the most significant 32 bits.

Top module: `fprf_top`

## Requirements
- R1: After reset is released, every word reads as zero.
- R2: When `clr` is high at a rising clock edge, all words are zero after that edge, and a write presented in the same cycle has no effect.
- R3: A write with code 0 (single) and an in-range index n stores `wr_data[31:0]` into word n at the clock edge and leaves every other word unchanged.
- R4: A write with code 1 (double) stores `wr_data[63:32]` into word n and `wr_data[31:0]` into word n+1, so that the singles n and n+1 read back those halves.
- R5: Reads are combinational. Code 0 returns word n on `rd_data[31:0]` with the upper bits zero. Code 1 returns `{word n, word n+1}` on `rd_data[63:0]` with the upper bits zero. Code 2 (quad) returns `{word n, word n+1, word n+2, word n+3}` on `rd_data[127:0]`.
- R6: A write with code 2 (quad) raises `wr_err` in the same cycle and leaves the storage unchanged.
- R7: Code 3 is illegal. On the read port it raises `rd_err` and forces `rd_data` to zero. On the write port it raises `wr_err`, and the storage does not change.
- R8: An access whose last word would be at or above `NUM_WORDS` raises the error of its port. Such a read returns zero, and such a write changes nothing.
- R9: `wr_err` stays low while `wr_en` is low, whatever the write code and index are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of all storage |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Register number of the write |
| wr_code | input | 2 | Write width code (0 single, 1 double, 2 quad, 3 illegal) |
| wr_data | input | 128 | Write value, right-aligned |
| wr_err | output | 1 | Write rejected (illegal width, quad, or out of range) |
| rd_idx | input | IDX_W | Register number of the read |
| rd_code | input | 2 | Read width code |
| rd_data | output | 128 | Read value, right-aligned, zero on error |
| rd_err | output | 1 | Read rejected (illegal width or out of range) |

## Verification
The bench builds the block with `NUM_WORDS = 8`. With so few words, random indices land on the top words often: double and quad accesses that run past the end happen in a good share of the operations, and each random write overlaps words that later random reads return. Directed cases cover the reset state, a clear that collides with a write, a quad write, the illegal code on both ports, and the exact boundary at which a double or quad access just fits.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  localparam int WORD_W = 32;
  localparam int DATA_W = 128;
  localparam int MAX_SPAN = DATA_W / WORD_W;

  typedef enum logic [1:0] {
    FW_SGL  = 2'd0,
    FW_DBL  = 2'd1,
    FW_QUAD = 2'd2,
    FW_BAD  = 2'd3
  } fw_code_e;

  // number of words an access of this width covers, 0 if illegal
  function automatic logic [2:0] span_of(input fw_code_e code);
    case (code)
      FW_SGL:  span_of = 3'd1;
      FW_DBL:  span_of = 3'd2;
      FW_QUAD: span_of = 3'd4;
      default: span_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fprf_span_chk.sv
module fprf_span_chk
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS  = 32,
  parameter bit ALLOW_QUAD = 1'b1,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int EXT_W = IDX_W + 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       code,
  output logic             ok,
  output logic [2:0]       span
);

  logic [EXT_W-1:0] end_pos;
  logic             code_ok;
  logic             fits;

  always_comb begin
    span    = span_of(fw_code_e'(code));
    code_ok = (span != 3'd0);
    if (!ALLOW_QUAD && fw_code_e'(code) == FW_QUAD) begin
      code_ok = 1'b0;
    end
    end_pos = EXT_W'(idx) + EXT_W'(span);
    fits    = (end_pos <= EXT_W'(NUM_WORDS));
    ok      = code_ok && fits;
  end

endmodule

// File: rtl/fprf_wr_steer.sv
module fprf_wr_steer
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int EXT_W = IDX_W + 1
) (
  input  logic                               go,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [2:0]                         span,
  input  logic [DATA_W-1:0]                  data,
  output logic [NUM_WORDS-1:0]               wen,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   wdat
);

  logic [EXT_W-1:0] base;
  logic             is_dbl;

  assign base   = EXT_W'(idx);
  assign is_dbl = (span == 3'd2);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic hit_first;
    logic hit_second;
    assign hit_first  = (base == EXT_W'(k));
    assign hit_second = is_dbl && (base + EXT_W'(1) == EXT_W'(k));
    assign wen[k]  = go && (hit_first || hit_second);
    assign wdat[k] = (hit_first && is_dbl) ? data[2*WORD_W-1:WORD_W]
                                           : data[WORD_W-1:0];
  end

  // a legal write touches at most two words
  always_comb begin
    AST_WEN_LIMIT: assert ($countones(wen) <= 2); // R4
  end

endmodule

// File: rtl/fprf_store.sv
module fprf_store
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic [NUM_WORDS-1:0]             wen,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] wdat,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] mem
);

  logic [NUM_WORDS-1:0][WORD_W-1:0] mem_nxt;
  logic                             upd;

  always_comb begin
    mem_nxt = mem;
    if (clr) begin
      mem_nxt = '0;
    end else begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (wen[k]) begin
          mem_nxt[k] = wdat[k];
        end
      end
    end
  end

  assign upd = clr || (|wen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (upd) begin
      mem <= mem_nxt;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wen == '0) |=> $stable(mem)); // R3

endmodule

// File: rtl/fprf_rd_mux.sv
module fprf_rd_mux
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int EXT_W = IDX_W + 3
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] mem,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [2:0]                       span,
  input  logic                             ok,
  output logic [DATA_W-1:0]                data
);

  logic [MAX_SPAN-1:0][WORD_W-1:0] win;

  for (genvar i = 0; i < MAX_SPAN; i++) begin : g_win
    logic [EXT_W-1:0] pos;
    assign pos = EXT_W'(idx) + EXT_W'(i);
    always_comb begin
      win[i] = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (pos == EXT_W'(k)) begin
          win[i] = mem[k];
        end
      end
    end
  end

  always_comb begin
    data = '0;
    if (ok) begin
      case (span)
        3'd1:    data = {{(DATA_W-WORD_W){1'b0}}, win[0]};
        3'd2:    data = {{(DATA_W-2*WORD_W){1'b0}}, win[0], win[1]};
        3'd4:    data = {win[0], win[1], win[2], win[3]};
        default: data = '0;
      endcase
    end
  end

endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_code,
  input  logic [127:0]      wr_data,
  output logic              wr_err,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_code,
  output logic [127:0]      rd_data,
  output logic              rd_err
);

  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync[1];

  logic                             wr_ok;
  logic [2:0]                       wr_span;
  logic                             rd_ok;
  logic [2:0]                       rd_span;
  logic                             wr_go;
  logic [NUM_WORDS-1:0]             wen;
  logic [NUM_WORDS-1:0][WORD_W-1:0] wdat;
  logic [NUM_WORDS-1:0][WORD_W-1:0] mem;

  fprf_span_chk #(.NUM_WORDS(NUM_WORDS), .ALLOW_QUAD(1'b0)) u_wr_chk (
    .idx  (wr_idx),
    .code (wr_code),
    .ok   (wr_ok),
    .span (wr_span)
  );

  fprf_span_chk #(.NUM_WORDS(NUM_WORDS), .ALLOW_QUAD(1'b1)) u_rd_chk (
    .idx  (rd_idx),
    .code (rd_code),
    .ok   (rd_ok),
    .span (rd_span)
  );

  assign wr_go  = wr_en && wr_ok && !clr;
  assign wr_err = wr_en && !wr_ok;
  assign rd_err = !rd_ok;

  fprf_wr_steer #(.NUM_WORDS(NUM_WORDS)) u_steer (
    .go   (wr_go),
    .idx  (wr_idx),
    .span (wr_span),
    .data (wr_data),
    .wen  (wen),
    .wdat (wdat)
  );

  fprf_store #(.NUM_WORDS(NUM_WORDS)) u_store (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (clr),
    .wen   (wen),
    .wdat  (wdat),
    .mem   (mem)
  );

  fprf_rd_mux #(.NUM_WORDS(NUM_WORDS)) u_rd (
    .mem  (mem),
    .idx  (rd_idx),
    .span (rd_span),
    .ok   (rd_ok),
    .data (rd_data)
  );

  AST_QUAD_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && wr_code == 2'd2) |-> wr_err); // R6

  AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_err && !clr) |=> $stable(mem)); // R7

  AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_err |-> (rd_data == '0)); // R8

  AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!rd_err && rd_code == 2'd0) |-> (rd_data[127:32] == '0)); // R5

  AST_WR_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !wr_en |-> !wr_err); // R9

endmodule

// File: tb/fprf_top_tb.sv
module fprf_top_tb_top;

  localparam int NW = 8;
  localparam int IW = $clog2(NW);

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [1:0]    wr_code;
  logic [127:0]  wr_data;
  logic          wr_err;
  logic [IW-1:0] rd_idx;
  logic [1:0]    rd_code;
  logic [127:0]  rd_data;
  logic          rd_err;

  int total;
  int bad;
  bit finished;
  logic [31:0] model [NW];

  fprf_top #(.NUM_WORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .wr_data(wr_data), .wr_err(wr_err), .rd_idx(rd_idx),
    .rd_code(rd_code), .rd_data(rd_data), .rd_err(rd_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int words_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit legal(input int idx, input logic [1:0] c, input bit is_wr);
    int s;
    s = words_of(c);
    if (s == 0) return 1'b0;
    if (is_wr && c == 2'd2) return 1'b0;
    return (idx + s <= NW);
  endfunction

  function automatic logic [127:0] exp_rd(input int idx, input logic [1:0] c);
    logic [127:0] v;
    int s;
    v = '0;
    if (!legal(idx, c, 1'b0)) return v;
    s = words_of(c);
    for (int i = 0; i < s; i++) begin
      v = (v << 32) | 128'(model[idx + i]);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check comb outputs, let edge commit
  task automatic step(input bit c, input bit we, input int wi, input logic [1:0] wc,
                      input logic [127:0] wd, input int ri, input logic [1:0] rc,
                      input string req);
    @(negedge clk);
    clr = c; wr_en = we; wr_idx = IW'(wi); wr_code = wc; wr_data = wd;
    rd_idx = IW'(ri); rd_code = rc;
    #1;
    check({req, " rd_data"}, rd_data, exp_rd(ri, rc));
    check({req, " rd_err"}, 128'(rd_err), 128'(!legal(ri, rc, 1'b0)));
    check({req, " wr_err"}, 128'(wr_err), 128'(we && !legal(wi, wc, 1'b1)));
    @(posedge clk);
    if (c) begin
      for (int k = 0; k < NW; k++) model[k] = '0;
    end else if (we && legal(wi, wc, 1'b1)) begin
      if (wc == 2'd0) model[wi] = wd[31:0];
      else begin
        model[wi] = wd[63:32];
        model[wi + 1] = wd[31:0];
      end
    end
  endtask

  task automatic rd_only(input int ri, input logic [1:0] rc, input string req);
    step(1'b0, 1'b0, 0, 2'd0, '0, ri, rc, req);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    total = 0; bad = 0; finished = 0;
    for (int k = 0; k < NW; k++) model[k] = '0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_code = '0;
    wr_data = '0; rd_idx = '0; rd_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: everything zero after reset
    for (int k = 0; k < NW; k++) rd_only(k, 2'd0, "R1");
    rd_only(0, 2'd2, "R1");

    // R3: single writes
    step(1'b0, 1'b1, 3, 2'd0, 128'hAAAA_1111, 3, 2'd0, "R3");
    rd_only(3, 2'd0, "R3");
    rd_only(2, 2'd0, "R3");
    // R4: double overlaps singles 4 and 5; R5 double/quad views
    step(1'b0, 1'b1, 4, 2'd1, 128'h0123_4567_89AB_CDEF, 4, 2'd0, "R4");
    rd_only(4, 2'd0, "R4");
    rd_only(5, 2'd0, "R4");
    rd_only(4, 2'd1, "R5");
    rd_only(3, 2'd2, "R5");
    rd_only(3, 2'd1, "R5");
    // R6: quad write rejected
    step(1'b0, 1'b1, 0, 2'd2, {4{32'hDEAD_BEEF}}, 0, 2'd2, "R6");
    rd_only(0, 2'd2, "R6");
    // R7: illegal code on both ports
    step(1'b0, 1'b1, 1, 2'd3, 128'h5555, 1, 2'd3, "R7");
    rd_only(1, 2'd0, "R7");
    // R8: boundaries
    step(1'b0, 1'b1, NW-1, 2'd1, 128'hFFFF_0000_FFFF, NW-1, 2'd1, "R8");
    rd_only(NW-1, 2'd0, "R8");
    step(1'b0, 1'b1, NW-2, 2'd1, 128'h1234_0000_5678, NW-4, 2'd2, "R8");
    rd_only(NW-4, 2'd2, "R8");
    rd_only(NW-3, 2'd2, "R8");
    // R9: no write request, no write error
    step(1'b0, 1'b0, NW-1, 2'd3, '0, 0, 2'd0, "R9");
    // R2: clear collides with a write
    step(1'b1, 1'b1, 2, 2'd0, 128'h77, 2, 2'd0, "R2");
    rd_only(2, 2'd0, "R2");
    rd_only(4, 2'd2, "R2");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      sel = $urandom_range(0, 99);
      step(sel < 2, $urandom_range(0, 3) != 0, $urandom_range(0, NW-1),
           2'($urandom_range(0, 3)), rnd128(), $urandom_range(0, NW-1),
           2'($urandom_range(0, 3)), "R5");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule